// File: doc/BRIEF.md
# Indirect Flash Transfer Controller

This block moves data between a serial flash command back-end and a small on-chip word buffer. The buffer is split in two. The lower region queues words fetched from the flash for the host to collect, and the upper region queues words the host has pushed for programming. Software first sets a flash start address and a byte count. It then starts either a read or a write and polls a sticky completion flag. It can abort the transfer at any time.

The back-end is reached through a byte-wide request/acknowledge handshake. Each request carries the address of one byte, which is the start address plus the byte offset. A read request returns the byte on the acknowledge. A write request carries the byte to program. Bytes are packed little-endian into 32-bit words: the byte at offset 4k+j goes to bits [8j+7:8j] of word k. The host reads and writes the buffer through a word port, and reads the fill level of each region through a register.

Top module: `ift_ctrl`

Register map (index on `reg_addr_i`):
- 0 control. Write bit0 to start a read, bit1 to start a write and bit2 to abort. Write 1 to bit4 to clear the read completion flag and 1 to bit5 to clear the write completion flag. Read back bit4 as the read completion flag, bit5 as the write completion flag and bit8 as busy.
- 1 start address.
- 2 byte count.
- 3 read region size in words.
- 4 fill levels.
- 5 address size.

## Requirements
- R1: After reset the following values hold: the control register reads 0, the byte count reads 0, the read region size reads DEPTH/2 (8), the address size reads 2, the level register reads 0, and `be_req_o` is low.
- R2: The read region holds the number of words in register 3, and the write region holds the remaining DEPTH minus that value. A write of 0, or of a value of DEPTH or more, is ignored. An accepted write to register 3 empties both regions.
- R3: Register 4 reports the read region fill level in words in bits [15:0] and the write region fill level in words in bits [31:16].
- R4: Starting a read fetches exactly the programmed count of bytes from consecutive addresses beginning at the start address. The bytes are packed little-endian into words in the read region, and the host collects those words in order through `host_rdata_o`/`host_pop_i`.
- R5: A read issues no request while the read region is full. It resumes when the host frees a word, and it never loses or repeats a byte.
- R6: When the count is not a multiple of four, the last read word has its unfilled upper bytes set to zero.
- R7: Starting a write takes words from the write region and sends their bytes lane 0 first, at consecutive addresses from the start address. Exactly the programmed count of bytes is sent, and the unused bytes of the last word are discarded.
- R8: A host push while the write region is full is dropped. A host pop while the read region is empty changes nothing.
- R9: A completion flag sets when the last byte of its transfer is acknowledged, and it stays set until software writes 1 to its clear bit. Starting a transfer with a count of 0 sets the flag at once and issues no request.
- R10: An abort drops the request on the next cycle, empties both regions, clears busy and leaves both completion flags unchanged.
- R11: Register 5 holds the number of address bytes minus one. Only the values 2 (three bytes) and 3 (four bytes) are accepted, and any other write is ignored. `be_abytes_o` gives the number of address bytes. In three-byte mode, bits [31:24] of `be_addr_o` are zero.
- R12: While a transfer is busy, a new start request and any write to registers 1, 2, 3 or 5 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| host_push_i | input | 1 | Push a word into the write region |
| host_wdata_i | input | 32 | Word to push |
| host_pop_i | input | 1 | Pop the head of the read region |
| host_rdata_o | output | 32 | Head word of the read region |
| be_req_o | output | 1 | Byte request to the back-end |
| be_we_o | output | 1 | The request is a program byte (1) or a fetch (0) |
| be_addr_o | output | 32 | Flash address of the requested byte |
| be_abytes_o | output | 3 | Number of address bytes, 3 or 4 |
| be_wdata_o | output | 8 | Byte to program |
| be_rdata_i | input | 8 | Fetched byte, valid with the acknowledge |
| be_ack_i | input | 1 | Back-end accepts the current byte |

## Verification
The assertions assume that the back-end never acknowledges a request that is not asserted. They also assume that a held request only ever ends through an acknowledge or an abort. The bench back-end honours both rules: it acknowledges only while a request is visible, for a single cycle, and it leaves an idle cycle between acknowledges. Fetched bytes are a fixed function of the address, so every word the host pops can be predicted. The host pops only after it has read a non-zero read level, and it overfills the write region only on purpose, to exercise the drop behaviour.

// File: rtl/ift_pkg.sv
package ift_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned WORD_W = 32;

  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_ADDR  = 3'd1;
  localparam logic [2:0] REG_COUNT = 3'd2;
  localparam logic [2:0] REG_PART  = 3'd3;
  localparam logic [2:0] REG_LEVEL = 3'd4;
  localparam logic [2:0] REG_ASIZE = 3'd5;

  localparam int unsigned CB_RD_GO  = 0;
  localparam int unsigned CB_WR_GO  = 1;
  localparam int unsigned CB_ABORT  = 2;
  localparam int unsigned CB_RD_DN  = 4;
  localparam int unsigned CB_WR_DN  = 5;
  localparam int unsigned CB_BUSY   = 8;

  typedef enum logic [1:0] {ENG_IDLE, ENG_RD, ENG_WR} eng_state_e;
endpackage

// File: rtl/ift_ring.sv
module ift_ring #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic [LW-1:0] cap_i,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [PW-1:0] wr_idx_o,
  output logic [PW-1:0] rd_idx_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [PW-1:0] wr_q, rd_q;
  logic [LW-1:0] lvl_q;
  logic push_ok, pop_ok, wr_wrap, rd_wrap;

  assign full_o   = (lvl_q == cap_i);
  assign empty_o  = (lvl_q == '0);
  assign push_ok  = push_i && !full_o;
  assign pop_ok   = pop_i && !empty_o;
  assign wr_wrap  = (LW'(wr_q) == cap_i - LW'(1));
  assign rd_wrap  = (LW'(rd_q) == cap_i - LW'(1));
  assign wr_idx_o = wr_q;
  assign rd_idx_o = rd_q;
  assign level_o  = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (push_ok) wr_q <= wr_wrap ? '0 : wr_q + PW'(1);
      if (pop_ok)  rd_q <= rd_wrap ? '0 : rd_q + PW'(1);
      lvl_q <= lvl_q + LW'(push_ok) - LW'(pop_ok);
    end
  end

  // R5
  level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= cap_i);
endmodule

// File: rtl/ift_sram.sv
module ift_sram #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W = 32,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_a_i,
  input  logic [AW-1:0] waddr_a_i,
  input  logic [W-1:0]  wdata_a_i,
  input  logic          we_b_i,
  input  logic [AW-1:0] waddr_b_i,
  input  logic [W-1:0]  wdata_b_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [W-1:0]  rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_b_o
);
  logic [W-1:0] mem_q [DEPTH];

  // regions are disjoint, so the two write ports never collide
  always_ff @(posedge clk_i) begin
    if (we_a_i) mem_q[waddr_a_i] <= wdata_a_i;
    if (we_b_i) mem_q[waddr_b_i] <= wdata_b_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/ift_engine.sv
module ift_engine
  import ift_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_go_i,
  input  logic              wr_go_i,
  input  logic              abort_i,
  input  logic [CW-1:0]     count_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              four_byte_i,
  input  logic              rd_full_i,
  input  logic              wr_empty_i,
  input  logic [WORD_W-1:0] wr_word_i,
  output logic              busy_o,
  output logic              rd_push_o,
  output logic [WORD_W-1:0] rd_word_o,
  output logic              wr_pop_o,
  output logic              done_rd_o,
  output logic              done_wr_o,
  output logic              be_req_o,
  output logic              be_we_o,
  output logic [ADDR_W-1:0] be_addr_o,
  output logic [7:0]        be_wdata_o,
  input  logic [7:0]        be_rdata_i,
  input  logic              be_ack_i
);
  eng_state_e state_q;
  logic [CW-1:0] off_q;
  logic [WORD_W-1:0] asm_q, word_q, merged;
  logic have_q, take, last, word_end, zero_cnt;
  logic [1:0] lane;
  logic [ADDR_W-1:0] full_addr;

  assign lane      = off_q[1:0];
  assign last      = (off_q == count_i - CW'(1));
  assign word_end  = (lane == 2'd3) || last;
  assign zero_cnt  = (count_i == '0);
  assign busy_o    = (state_q != ENG_IDLE);
  assign be_req_o  = ((state_q == ENG_RD) && !rd_full_i) || ((state_q == ENG_WR) && have_q);
  assign be_we_o   = (state_q == ENG_WR);
  assign take      = be_req_o && be_ack_i && !abort_i;
  assign full_addr = addr_i + ADDR_W'(off_q);
  assign be_addr_o = four_byte_i ? full_addr : {8'h00, full_addr[23:0]};
  assign be_wdata_o = word_q[{lane, 3'b000} +: 8];
  assign merged    = asm_q | (WORD_W'(be_rdata_i) << {lane, 3'b000});
  assign rd_word_o = merged;
  assign rd_push_o = (state_q == ENG_RD) && take && word_end;
  assign wr_pop_o  = (state_q == ENG_WR) && !have_q && !wr_empty_i && !abort_i;
  assign done_rd_o = !abort_i && (((state_q == ENG_RD) && take && last) ||
                     ((state_q == ENG_IDLE) && rd_go_i && zero_cnt));
  assign done_wr_o = !abort_i && (((state_q == ENG_WR) && take && last) ||
                     ((state_q == ENG_IDLE) && !rd_go_i && wr_go_i && zero_cnt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENG_IDLE;
      off_q   <= '0;
      asm_q   <= '0;
      word_q  <= '0;
      have_q  <= 1'b0;
    end else if (abort_i) begin
      state_q <= ENG_IDLE;
      off_q   <= '0;
      asm_q   <= '0;
      have_q  <= 1'b0;
    end else begin
      case (state_q)
        ENG_IDLE: begin
          off_q  <= '0;
          asm_q  <= '0;
          have_q <= 1'b0;
          if (rd_go_i && !zero_cnt) state_q <= ENG_RD;
          else if (!rd_go_i && wr_go_i && !zero_cnt) state_q <= ENG_WR;
        end
        ENG_RD: if (take) begin
          asm_q <= word_end ? '0 : merged;
          off_q <= off_q + CW'(1);
          if (last) state_q <= ENG_IDLE;
        end
        ENG_WR: begin
          if (wr_pop_o) begin
            word_q <= wr_word_i;
            have_q <= 1'b1;
          end
          if (take) begin
            off_q <= off_q + CW'(1);
            if (word_end) have_q <= 1'b0;
            if (last) state_q <= ENG_IDLE;
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_req_o && !be_ack_i && !abort_i |=> be_req_o && $stable(be_addr_o));
  // R10
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !busy_o && !be_req_o);
endmodule

// File: rtl/ift_ctrl.sv
module ift_ctrl
  import ift_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              host_push_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  input  logic              host_pop_i,
  output logic [WORD_W-1:0] host_rdata_o,
  output logic              be_req_o,
  output logic              be_we_o,
  output logic [ADDR_W-1:0] be_addr_o,
  output logic [2:0]        be_abytes_o,
  output logic [7:0]        be_wdata_o,
  input  logic [7:0]        be_rdata_i,
  input  logic              be_ack_i
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned LW = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] addr_q;
  logic [CW-1:0] count_q;
  logic [LW-1:0] part_q, wr_cap;
  logic [1:0] asize_q;
  logic rd_done_q, wr_done_q;
  logic busy, ctrl_wr, rd_go, wr_go, abort, part_ok, flush;
  logic rd_push, wr_pop, done_rd, done_wr;
  logic [WORD_W-1:0] rd_word, wr_word;
  logic [PW-1:0] rd_widx, rd_ridx, wr_widx, wr_ridx;
  logic [LW-1:0] rd_lvl, wr_lvl;
  logic rd_full, rd_empty, wr_full, wr_empty;

  assign ctrl_wr = reg_we_i && (reg_addr_i == REG_CTRL);
  assign rd_go   = ctrl_wr && reg_wdata_i[CB_RD_GO] && !busy;
  assign wr_go   = ctrl_wr && reg_wdata_i[CB_WR_GO] && !busy;
  assign abort   = ctrl_wr && reg_wdata_i[CB_ABORT];
  assign part_ok = reg_we_i && !busy && (reg_addr_i == REG_PART) &&
                   (reg_wdata_i != '0) && (reg_wdata_i < 32'(DEPTH));
  assign flush   = abort || part_ok;
  assign wr_cap  = LW'(DEPTH) - part_q;
  assign be_abytes_o = {1'b0, asize_q} + 3'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q    <= '0;
      count_q   <= '0;
      part_q    <= LW'(DEPTH / 2);
      asize_q   <= 2'd2;
      rd_done_q <= 1'b0;
      wr_done_q <= 1'b0;
    end else begin
      if (reg_we_i && !busy) begin
        case (reg_addr_i)
          REG_ADDR:  addr_q  <= reg_wdata_i;
          REG_COUNT: count_q <= reg_wdata_i[CW-1:0];
          REG_ASIZE: if (reg_wdata_i == 32'd2 || reg_wdata_i == 32'd3) asize_q <= reg_wdata_i[1:0];
          default: ;
        endcase
      end
      if (part_ok) part_q <= reg_wdata_i[LW-1:0];
      if (done_rd) rd_done_q <= 1'b1;
      else if (ctrl_wr && reg_wdata_i[CB_RD_DN]) rd_done_q <= 1'b0;
      if (done_wr) wr_done_q <= 1'b1;
      else if (ctrl_wr && reg_wdata_i[CB_WR_DN]) wr_done_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_CTRL: begin
        reg_rdata_o[CB_RD_DN] = rd_done_q;
        reg_rdata_o[CB_WR_DN] = wr_done_q;
        reg_rdata_o[CB_BUSY]  = busy;
      end
      REG_ADDR:  reg_rdata_o = addr_q;
      REG_COUNT: reg_rdata_o = 32'(count_q);
      REG_PART:  reg_rdata_o = 32'(part_q);
      REG_LEVEL: begin
        reg_rdata_o[LW-1:0]    = rd_lvl;
        reg_rdata_o[16 +: LW]  = wr_lvl;
      end
      REG_ASIZE: reg_rdata_o = 32'(asize_q);
      default: ;
    endcase
  end

  ift_ring #(.DEPTH(DEPTH)) u_rd_ring (
    .clk_i, .rst_ni, .flush_i(flush), .cap_i(part_q),
    .push_i(rd_push), .pop_i(host_pop_i),
    .wr_idx_o(rd_widx), .rd_idx_o(rd_ridx), .level_o(rd_lvl),
    .full_o(rd_full), .empty_o(rd_empty)
  );

  ift_ring #(.DEPTH(DEPTH)) u_wr_ring (
    .clk_i, .rst_ni, .flush_i(flush), .cap_i(wr_cap),
    .push_i(host_push_i), .pop_i(wr_pop),
    .wr_idx_o(wr_widx), .rd_idx_o(wr_ridx), .level_o(wr_lvl),
    .full_o(wr_full), .empty_o(wr_empty)
  );

  ift_sram #(.DEPTH(DEPTH), .W(WORD_W)) u_sram (
    .clk_i,
    .we_a_i(rd_push && !rd_full), .waddr_a_i(rd_widx), .wdata_a_i(rd_word),
    .we_b_i(host_push_i && !wr_full), .waddr_b_i(PW'(part_q + LW'(wr_widx))),
    .wdata_b_i(host_wdata_i),
    .raddr_a_i(rd_ridx), .rdata_a_o(host_rdata_o),
    .raddr_b_i(PW'(part_q + LW'(wr_ridx))), .rdata_b_o(wr_word)
  );

  ift_engine #(.CW(CW)) u_engine (
    .clk_i, .rst_ni, .rd_go_i(rd_go), .wr_go_i(wr_go), .abort_i(abort),
    .count_i(count_q), .addr_i(addr_q), .four_byte_i(asize_q == 2'd3),
    .rd_full_i(rd_full), .wr_empty_i(wr_empty), .wr_word_i(wr_word),
    .busy_o(busy), .rd_push_o(rd_push), .rd_word_o(rd_word), .wr_pop_o(wr_pop),
    .done_rd_o(done_rd), .done_wr_o(done_wr),
    .be_req_o, .be_we_o, .be_addr_o, .be_wdata_o, .be_rdata_i, .be_ack_i
  );

  // R10
  abort_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort && !reg_wdata_i[CB_RD_DN] && !reg_wdata_i[CB_WR_DN]
    |=> $stable(rd_done_q) && $stable(wr_done_q));
  // R2
  part_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    part_ok |=> (rd_lvl == '0) && (wr_lvl == '0));
endmodule

// File: tb/ift_ctrl_tb_top.sv
module ift_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic host_push = 1'b0;
  logic [31:0] host_wdata = '0;
  logic host_pop = 1'b0;
  logic [31:0] host_rdata;
  logic be_req, be_we, be_ack;
  logic [31:0] be_addr;
  logic [2:0] be_abytes;
  logic [7:0] be_wdata, be_rdata;

  int checks = 0;
  int errors = 0;
  int acks = 0;
  logic [31:0] exp_words [$];
  logic [39:0] exp_bytes [$];

  always #5 clk = ~clk;

  initial be_ack = 1'b0;
  assign be_rdata = be_addr[7:0] ^ 8'hA5;

  ift_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .host_push_i(host_push), .host_wdata_i(host_wdata),
    .host_pop_i(host_pop), .host_rdata_o(host_rdata),
    .be_req_o(be_req), .be_we_o(be_we), .be_addr_o(be_addr),
    .be_abytes_o(be_abytes), .be_wdata_o(be_wdata),
    .be_rdata_i(be_rdata), .be_ack_i(be_ack)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // back-end model and write-byte monitor
  always @(negedge clk) begin
    if (be_ack) be_ack = 1'b0;
    else if (rst_n && be_req) begin
      be_ack = 1'b1;
      acks++;
      if (be_we) begin
        logic [39:0] e;
        e = (exp_bytes.size() > 0) ? exp_bytes.pop_front() : 40'hFF_FFFF_FFFF;
        checks++;
        if ({be_addr, be_wdata} !== e) begin
          errors++;
          $display("FAIL R7 byte act=%h exp=%h", {be_addr, be_wdata}, e);
        end
      end
    end
  end

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic push_w(input logic [31:0] d);
    @(negedge clk);
    host_push = 1'b1; host_wdata = d;
    @(negedge clk);
    host_push = 1'b0;
  endtask

  task automatic wait_ctrl_bit(input int b, input string tag);
    logic [31:0] d;
    int n;
    n = 0;
    do begin
      @(negedge clk);
      rreg(3'd0, d);
      n++;
    end while (!d[b] && n < 2000);
    check(tag, 32'(d[b]), 32'd1);
  endtask

  task automatic exp_read(input logic [31:0] base, input int count);
    for (int k = 0; k < (count + 3) / 4; k++) begin
      logic [31:0] w;
      w = '0;
      for (int j = 0; j < 4; j++)
        if (4 * k + j < count) w[8*j +: 8] = 8'(base + 32'(4 * k + j)) ^ 8'hA5;
      exp_words.push_back(w);
    end
  endtask

  task automatic drain(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [31:0] d;
      int t;
      t = 0;
      do begin
        @(negedge clk);
        rreg(3'd4, d);
        t++;
      end while (d[15:0] == 16'd0 && t < 2000);
      check(tag, host_rdata, exp_words.pop_front());
      host_pop = 1'b1;
      @(negedge clk);
      host_pop = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int a0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rreg(3'd0, d); check("R1 ctrl", d, 32'h0);
    rreg(3'd2, d); check("R1 count", d, 32'h0);
    rreg(3'd3, d); check("R1 part", d, 32'd8);
    rreg(3'd5, d); check("R1 asize", d, 32'd2);
    rreg(3'd4, d); check("R1 level", d, 32'h0);
    check("R1 req", 32'(be_req), 32'd0);

    // R11 address size
    wreg(3'd5, 32'd0);
    rreg(3'd5, d); check("R11 bad size ignored", d, 32'd2);
    check("R11 abytes 3", 32'(be_abytes), 32'd3);
    wreg(3'd1, 32'hAB0000FC);
    @(negedge clk); check("R11 3-byte mask", be_addr, 32'h000000FC);
    wreg(3'd5, 32'd3);
    rreg(3'd5, d); check("R11 size 4", d, 32'd3);
    check("R11 abytes 4", 32'(be_abytes), 32'd4);
    @(negedge clk); check("R11 4-byte addr", be_addr, 32'hAB0000FC);
    wreg(3'd5, 32'd2);

    // R4 / R6 short read with padding
    wreg(3'd1, 32'h100);
    wreg(3'd2, 32'd10);
    a0 = acks;
    exp_read(32'h100, 10);
    wreg(3'd0, 32'h1);
    wait_ctrl_bit(4, "R9 read done");
    rreg(3'd4, d); check("R3 read level", d, 32'd3);
    check("R4 byte count", 32'(acks - a0), 32'd10);
    drain(3, "R4 R6 read word");
    @(negedge clk); rreg(3'd4, d); check("R3 drained", d, 32'd0);

    // R9 clear and zero count
    wreg(3'd0, 32'h10);
    rreg(3'd0, d); check("R9 cleared", d, 32'h0);
    wreg(3'd2, 32'd0);
    a0 = acks;
    wreg(3'd0, 32'h1);
    @(negedge clk); rreg(3'd0, d); check("R9 zero count done", d, 32'h10);
    check("R9 zero count no req", 32'(acks - a0), 32'd0);
    wreg(3'd0, 32'h10);

    // R5 stall on full read region, R12 writes while busy
    wreg(3'd1, 32'h300);
    wreg(3'd2, 32'd40);
    a0 = acks;
    exp_read(32'h300, 40);
    wreg(3'd0, 32'h1);
    repeat (200) @(negedge clk);
    rreg(3'd4, d); check("R5 level full", d, 32'd8);
    check("R5 stalled bytes", 32'(acks - a0), 32'd32);
    rreg(3'd0, d); check("R5 busy no done", d, 32'h100);
    wreg(3'd1, 32'h5555);
    rreg(3'd1, d); check("R12 addr held", d, 32'h300);
    wreg(3'd2, 32'd1);
    rreg(3'd2, d); check("R12 count held", d, 32'd40);
    wreg(3'd0, 32'h2);
    drain(10, "R5 read word");
    wait_ctrl_bit(4, "R5 done");
    check("R5 total bytes", 32'(acks - a0), 32'd40);
    rreg(3'd0, d); check("R12 start ignored", 32'(d[5]), 32'd0);
    wreg(3'd0, 32'h10);

    // R2 partition, R8 drops
    wreg(3'd3, 32'd0);
    rreg(3'd3, d); check("R2 zero ignored", d, 32'd8);
    wreg(3'd3, 32'd16);
    rreg(3'd3, d); check("R2 depth ignored", d, 32'd8);
    wreg(3'd3, 32'd4);
    rreg(3'd3, d); check("R2 accepted", d, 32'd4);
    for (int i = 0; i < 13; i++) push_w(32'(i));
    @(negedge clk); rreg(3'd4, d); check("R8 write region full", d, 32'h000C_0000);
    host_pop = 1'b1; @(negedge clk); host_pop = 1'b0;
    @(negedge clk); rreg(3'd4, d); check("R8 empty pop ignored", d[15:0], 32'd0);
    wreg(3'd3, 32'd8);
    @(negedge clk); rreg(3'd4, d); check("R2 flush", d, 32'h0);

    // R7 write with discarded tail bytes
    push_w(32'h44332211);
    push_w(32'h88776655);
    push_w(32'hCCBBAA99);
    @(negedge clk); rreg(3'd4, d); check("R3 write level", d, 32'h0003_0000);
    begin
      logic [31:0] ws [3];
      ws[0] = 32'h44332211; ws[1] = 32'h88776655; ws[2] = 32'hCCBBAA99;
      for (int i = 0; i < 10; i++)
        exp_bytes.push_back({32'h2000 + 32'(i), ws[i / 4][8 * (i % 4) +: 8]});
    end
    wreg(3'd1, 32'h2000);
    wreg(3'd2, 32'd10);
    a0 = acks;
    wreg(3'd0, 32'h2);
    wait_ctrl_bit(5, "R9 write done");
    check("R7 exact bytes", 32'(acks - a0), 32'd10);
    check("R7 all expected sent", 32'(exp_bytes.size()), 32'd0);
    rreg(3'd4, d); check("R7 region empty", d, 32'h0);
    wreg(3'd0, 32'h20);

    // R10 abort
    wreg(3'd1, 32'h400);
    wreg(3'd2, 32'd40);
    wreg(3'd0, 32'h1);
    repeat (30) @(negedge clk);
    push_w(32'hDEAD0001);
    wreg(3'd0, 32'h4);
    check("R10 req dropped", 32'(be_req), 32'd0);
    rreg(3'd0, d); check("R10 idle no done", d, 32'h0);
    rreg(3'd4, d); check("R10 flushed", d, 32'h0);
    a0 = acks;
    repeat (20) @(negedge clk);
    check("R10 no more bytes", 32'(acks - a0), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule